// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream and passes on only the packets whose packet identifier is wanted. It locates the 188-byte packet grid by the 0x47 sync byte, holds lock while the grid stays intact, and reads the 13-bit identifier from the header. The identifier is compared with every entry of a 64-entry selection table in the same cycle. Packets that pass are collected whole in an output buffer and released as a valid/ready byte stream that carries first-byte and last-byte markers.

The input stream cannot be stalled. It has a byte valid and a restart marker but no ready. When the output side falls behind, the buffer fills. Each new packet is then accepted or refused as a whole when its first byte arrives. A refused packet that the table would have passed increments a drop counter. On the output side, a byte is transferred on each cycle in which `pkt_valid` and `pkt_ready` are both high. While `pkt_valid` is high and `pkt_ready` is low, the block holds the byte and its markers unchanged.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset `pkt_valid`, `locked` and `drop_count` are 0 and every table entry is disabled, so no packet passes until an entry is written.
- R2: From search, three 0x47 bytes spaced exactly 188 accepted bytes apart set `locked` in the cycle after the third one. The packet that begins with that third sync byte is the first one that can be forwarded.
- R3: While locked, a byte other than 0x47 at an expected sync position counts as a miss, and the packet it begins is not forwarded. A single miss followed by a good sync keeps lock. A second consecutive miss clears `locked` in the next cycle.
- R4: The identifier is bits 4..0 of packet byte 1 (as bits 12..8) joined with packet byte 2 (bits 7..0); header bits 7..5 of byte 1 do not affect it. A packet passes if any entry with its enable set holds that identifier. An entry is written by `cfg_we` with `cfg_idx`, `cfg_enable` and `cfg_pid`.
- R5: Each forwarded packet leaves as all 188 bytes, unchanged and in arrival order, with `pkt_first` on byte 0 and `pkt_last` on byte 187. Packets leave in the order they arrived.
- R6: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and `pkt_data` stays stable. A packet becomes visible at the output only after its last byte has been received.
- R7: A packet is stored only if at least 188 bytes of the output buffer are free when its first byte arrives. Otherwise none of it is output. If such a refused packet would have passed the filter, `drop_count` increases by exactly 1.
- R8: With `drop_err_pkts` high, a packet with bit 7 of byte 1 (transport error) set is discarded and not counted as a drop. With `drop_err_pkts` low, such a packet is treated normally.
- R9: An accepted byte with `ts_start` high restarts the search. Lock clears, the packet in progress is discarded, and that byte is tested as a first sync candidate.
- R10: Cycles with `ts_valid` low are ignored whatever `ts_data` holds, so gaps inside or between packets do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Input byte valid |
| ts_start | input | 1 | Restart marker for the accompanying byte |
| ts_data | input | 8 | Input stream byte |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 6 | Table entry index |
| cfg_enable | input | 1 | Enable bit written to the entry |
| cfg_pid | input | 13 | Identifier written to the entry |
| drop_err_pkts | input | 1 | Discard packets whose transport-error bit is set |
| pkt_valid | output | 1 | Output byte valid |
| pkt_ready | input | 1 | Output consumer ready |
| pkt_data | output | 8 | Output byte |
| pkt_first | output | 1 | Output byte is byte 0 of its packet |
| pkt_last | output | 1 | Output byte is byte 187 of its packet |
| locked | output | 1 | Packet grid is locked |
| drop_count | output | 16 | Wrapping count of matching packets refused for lack of space |

## Verification
The bench compares the block against a behavioural model on every clock while it steps through lock acquisition, a lone miss, a double miss and a restart in the middle of a packet. A design that locked one sync early would forward the second packet, and one that dropped lock on the first miss would lose the packet after it. Holding the output back until the buffer holds two packets tests the whole-packet room rule: a design that truncated packets, or that counted non-matching refusals as drops, would emit partial packets or show the wrong drop count. Garbage 0x47 bytes presented with `ts_valid` low, and identifiers that differ only in high header bits or sit in a disabled entry, catch designs that sample invalid cycles or mask the identifier wrongly.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam logic [7:0] SYNC_VAL = 8'h47;

  typedef enum logic [1:0] {
    SY_SEARCH = 2'd0,
    SY_VERIFY = 2'd1,
    SY_LOCKED = 2'd2
  } sync_st_e;
endpackage

// File: rtl/tsf_sync.sv
module tsf_sync #(
  parameter int PKT_LEN     = 188,
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_vld,
  input  logic                       restart,
  input  logic [7:0]                 byte_in,
  output logic [$clog2(PKT_LEN)-1:0] pos,
  output logic                       head,
  output logic                       locked
);
  import tsf_pkg::*;

  localparam int POS_W = $clog2(PKT_LEN);
  localparam int MAXC  = (LOCK_HITS > LOSS_MISSES) ? LOCK_HITS : LOSS_MISSES;
  localparam int CW    = $clog2(MAXC + 1);

  sync_st_e          st_q, st_n;
  logic [POS_W-1:0]  pos_q, pos_n, pos_adv;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              is_sync;

  assign is_sync = (byte_in == SYNC_VAL);
  assign pos_adv = (pos_q == POS_W'(PKT_LEN - 1)) ? '0 : pos_q + POS_W'(1);

  always_comb begin
    st_n  = st_q;
    pos_n = pos_q;
    cnt_n = cnt_q;
    head  = 1'b0;
    if (byte_vld) begin
      if (restart || st_q == SY_SEARCH) begin
        if (is_sync) begin
          st_n  = SY_VERIFY;
          cnt_n = CW'(1);
          pos_n = POS_W'(1);
        end else begin
          st_n  = SY_SEARCH;
          cnt_n = '0;
          pos_n = '0;
        end
      end else begin
        pos_n = pos_adv;
        if (pos_q == '0) begin
          if (st_q == SY_VERIFY) begin
            if (!is_sync) begin
              st_n  = SY_SEARCH;
              cnt_n = '0;
              pos_n = '0;
            end else if (cnt_q == CW'(LOCK_HITS - 1)) begin
              st_n  = SY_LOCKED;
              cnt_n = '0;
              head  = 1'b1;
            end else begin
              cnt_n = cnt_q + CW'(1);
            end
          end else begin
            if (is_sync) begin
              cnt_n = '0;
              head  = 1'b1;
            end else if (cnt_q == CW'(LOSS_MISSES - 1)) begin
              st_n  = SY_SEARCH;
              cnt_n = '0;
              pos_n = '0;
            end else begin
              cnt_n = cnt_q + CW'(1);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SY_SEARCH;
      pos_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      pos_q <= pos_n;
      cnt_q <= cnt_n;
    end
  end

  assign pos    = pos_q;
  assign locked = (st_q == SY_LOCKED);

  AST_LOCK_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !$past(locked)) |-> ($past(byte_vld) && $past(byte_in) == SYNC_VAL)); // R2
  AST_LOSS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && $past(locked)) |-> ($past(restart) || $past(byte_in) != SYNC_VAL)); // R3
endmodule

// File: rtl/tsf_pid_table.sv
module tsf_pid_table #(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_enable,
  input  logic [PID_W-1:0]           wr_pid,
  input  logic [PID_W-1:0]           pid_in,
  output logic                       hit
);
  logic [ENTRIES-1:0] match_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic             en_q;
    logic [PID_W-1:0] pid_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        pid_q <= '0;
      end else if (wr_en && wr_idx == e) begin
        en_q  <= wr_enable;
        pid_q <= wr_pid;
      end
    end

    assign match_vec[e] = en_q && (pid_q == pid_in);
  end

  assign hit = |match_vec;
endmodule

// File: rtl/tsf_pkt_fifo.sv
module tsf_pkt_fifo #(
  parameter int DEPTH   = 512,
  parameter int PKT_LEN = 188
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       commit,
  input  logic       rewind,
  output logic       room,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int OPW   = $clog2(PKT_LEN);

  logic [7:0]     mem [DEPTH];
  logic [PW-1:0]  wsp_q, wcm_q, rd_q;
  logic [PW-1:0]  level, spec_level;
  logic [OPW-1:0] opos_q;
  logic           pop;

  assign level      = wcm_q - rd_q;
  assign spec_level = wsp_q - rd_q;
  assign room       = (level <= PW'(DEPTH - PKT_LEN));
  assign out_valid  = (rd_q != wcm_q);
  assign out_data   = mem[rd_q[AW-1:0]];
  assign out_first  = (opos_q == '0);
  assign out_last   = (opos_q == OPW'(PKT_LEN - 1));
  assign pop        = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wsp_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsp_q  <= '0;
      wcm_q  <= '0;
      rd_q   <= '0;
      opos_q <= '0;
    end else begin
      if (rewind)     wsp_q <= wcm_q;
      else if (wr_en) wsp_q <= wsp_q + PW'(1);
      if (commit)     wcm_q <= wsp_q + PW'(wr_en);
      if (pop) begin
        rd_q   <= rd_q + PW'(1);
        opos_q <= out_last ? '0 : opos_q + OPW'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (spec_level < PW'(DEPTH))); // R7
  AST_WHOLE_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_en) |-> ((wsp_q - wcm_q) == PW'(PKT_LEN - 1))); // R5
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R6
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter #(
  parameter int PKT_LEN     = 188,
  parameter int TABLE_SIZE  = 64,
  parameter int PID_W       = 13,
  parameter int FIFO_DEPTH  = 512,
  parameter int CNT_W       = 16,
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ts_valid,
  input  logic                          ts_start,
  input  logic [7:0]                    ts_data,
  input  logic                          cfg_we,
  input  logic [$clog2(TABLE_SIZE)-1:0] cfg_idx,
  input  logic                          cfg_enable,
  input  logic [PID_W-1:0]              cfg_pid,
  input  logic                          drop_err_pkts,
  output logic                          pkt_valid,
  input  logic                          pkt_ready,
  output logic [7:0]                    pkt_data,
  output logic                          pkt_first,
  output logic                          pkt_last,
  output logic                          locked,
  output logic [CNT_W-1:0]              drop_count
);
  localparam int POS_W  = $clog2(PKT_LEN);
  localparam int PHI_W  = PID_W - 8;

  logic [POS_W-1:0] pos;
  logic             head;
  logic             hit;
  logic             room;
  logic             wr_en, commit, rewind, drop_inc, pass;
  logic             in_pkt_q, in_pkt_n;
  logic             keep_q, keep_n;
  logic             room_q, room_n;
  logic             terr_q, terr_n;
  logic [PHI_W-1:0] phi_q, phi_n;
  logic [PID_W-1:0] pid_cur;

  tsf_sync #(
    .PKT_LEN(PKT_LEN), .LOCK_HITS(LOCK_HITS), .LOSS_MISSES(LOSS_MISSES)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .byte_vld(ts_valid), .restart(ts_start),
    .byte_in(ts_data), .pos(pos), .head(head), .locked(locked)
  );

  assign pid_cur = {phi_q, ts_data};

  tsf_pid_table #(.ENTRIES(TABLE_SIZE), .PID_W(PID_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_enable(cfg_enable), .wr_pid(cfg_pid), .pid_in(pid_cur), .hit(hit)
  );

  tsf_pkt_fifo #(.DEPTH(FIFO_DEPTH), .PKT_LEN(PKT_LEN)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(ts_data),
    .commit(commit), .rewind(rewind), .room(room),
    .out_valid(pkt_valid), .out_ready(pkt_ready), .out_data(pkt_data),
    .out_first(pkt_first), .out_last(pkt_last)
  );

  assign pass = hit && !(drop_err_pkts && terr_q);

  always_comb begin
    wr_en    = 1'b0;
    commit   = 1'b0;
    rewind   = 1'b0;
    drop_inc = 1'b0;
    in_pkt_n = in_pkt_q;
    keep_n   = keep_q;
    room_n   = room_q;
    terr_n   = terr_q;
    phi_n    = phi_q;
    if (ts_valid) begin
      if (ts_start) begin
        if (in_pkt_q) begin
          in_pkt_n = 1'b0;
          rewind   = keep_q;
          keep_n   = 1'b0;
        end
      end else if (head) begin
        in_pkt_n = 1'b1;
        keep_n   = room;
        room_n   = room;
        wr_en    = room;
      end else if (in_pkt_q) begin
        if (pos == POS_W'(1)) begin
          terr_n = ts_data[7];
          phi_n  = ts_data[PHI_W-1:0];
        end
        if (pos == POS_W'(2)) begin
          drop_inc = pass && !room_q;
          if (keep_q && !pass) begin
            rewind = 1'b1;
            keep_n = 1'b0;
          end else begin
            wr_en = keep_q;
          end
        end else begin
          wr_en = keep_q;
        end
        if (pos == POS_W'(PKT_LEN - 1)) begin
          in_pkt_n = 1'b0;
          commit   = keep_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q   <= 1'b0;
      keep_q     <= 1'b0;
      room_q     <= 1'b0;
      terr_q     <= 1'b0;
      phi_q      <= '0;
      drop_count <= '0;
    end else begin
      in_pkt_q <= in_pkt_n;
      keep_q   <= keep_n;
      room_q   <= room_n;
      terr_q   <= terr_n;
      phi_q    <= phi_n;
      if (drop_inc) drop_count <= drop_count + CNT_W'(1);
    end
  end

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + CNT_W'(1))); // R7
  AST_WRITE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !head) |-> locked); // R2
  AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && ts_start) |=> !locked); // R9
endmodule

// File: tb/ts_pid_filter_test.sv
module ts_pid_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_valid = 1'b0, ts_start = 1'b0;
  logic [7:0]  ts_data = 8'h47;
  logic        cfg_we = 1'b0, cfg_enable = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [12:0] cfg_pid = '0;
  logic        drop_err_pkts = 1'b0;
  logic        pkt_valid, pkt_ready, pkt_first, pkt_last, locked;
  logic [7:0]  pkt_data;
  logic [15:0] drop_count;

  always #5 clk = ~clk;

  ts_pid_filter uut (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_start(ts_start), .ts_data(ts_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_enable(cfg_enable), .cfg_pid(cfg_pid),
    .drop_err_pkts(drop_err_pkts), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_first(pkt_first), .pkt_last(pkt_last),
    .locked(locked), .drop_count(drop_count)
  );

  int checks = 0, errors = 0, cyc = 0, fwd = 0, seed = 0;
  int ready_mode = 1;
  logic [15:0] lfsr = 16'hACE1;

  // bench-side table
  bit          t_en  [64];
  logic [12:0] t_pid [64];

  // reference model state
  logic [7:0] exp_q[$];
  logic [7:0] m_pkt[$];
  int m_st = 0, m_pos = 0, m_cnt = 0, m_oidx = 0;
  bit m_inpkt = 0, m_keep = 0, m_room = 0, m_terr = 0, m_locked = 0;
  logic [4:0] m_phi = '0;
  int m_drop = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit tbl_hit(input logic [12:0] p);
    for (int i = 0; i < 64; i++) if (t_en[i] && t_pid[i] == p) return 1;
    return 0;
  endfunction

  // output ready driver
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pkt_ready <= (ready_mode == 2) ? lfsr[3] : (ready_mode == 1);
  end

  // reference model, one step per clock
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_q.delete(); m_pkt.delete();
      m_st = 0; m_pos = 0; m_cnt = 0; m_oidx = 0; m_inpkt = 0; m_keep = 0;
      m_drop = 0; m_locked = 0;
    end else begin
      int sz, p;
      bit hd, cmt, ps;
      sz = exp_q.size(); cmt = 0; hd = 0;
      if (pkt_valid && pkt_ready && pkt_last) fwd++;
      if (ts_valid) begin
        p = m_pos;
        if (ts_start) begin
          if (m_inpkt) begin m_inpkt = 0; m_pkt.delete(); end
          if (ts_data == 8'h47) begin m_st = 1; m_cnt = 1; m_pos = 1; end
          else m_st = 0;
        end else if (m_st == 0) begin
          if (ts_data == 8'h47) begin m_st = 1; m_cnt = 1; m_pos = 1; end
        end else begin
          m_pos = (m_pos + 1) % 188;
          if (p == 0) begin
            if (m_st == 1) begin
              if (ts_data != 8'h47) m_st = 0;
              else if (m_cnt == 2) begin m_st = 2; m_cnt = 0; hd = 1; end
              else m_cnt++;
            end else begin
              if (ts_data == 8'h47) begin m_cnt = 0; hd = 1; end
              else if (m_cnt == 1) begin m_st = 0; m_cnt = 0; end
              else m_cnt = 1;
            end
          end
        end
        if (hd) begin
          m_inpkt = 1; m_keep = ((512 - sz) >= 188); m_room = m_keep;
          m_pkt.delete();
          if (m_keep) m_pkt.push_back(ts_data);
        end else if (m_inpkt && !ts_start) begin
          if (p == 1) begin m_terr = ts_data[7]; m_phi = ts_data[4:0]; end
          if (p == 2) begin
            ps = tbl_hit({m_phi, ts_data}) && !(drop_err_pkts && m_terr);
            if (ps && !m_room) m_drop++;
            if (!ps) begin m_keep = 0; m_pkt.delete(); end
          end
          if (m_keep) m_pkt.push_back(ts_data);
          if (p == 187) begin m_inpkt = 0; cmt = m_keep; end
        end
      end
      if (sz > 0 && pkt_ready) begin
        void'(exp_q.pop_front());
        m_oidx = (m_oidx + 1) % 188;
      end
      if (cmt) begin
        foreach (m_pkt[i]) exp_q.push_back(m_pkt[i]);
        m_pkt.delete();
      end
      m_locked = (m_st == 2);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(pkt_valid === (exp_q.size() > 0), "R6 pkt_valid", pkt_valid, exp_q.size() > 0);
      if (exp_q.size() > 0 && pkt_valid === 1'b1) begin
        chk(pkt_data === exp_q[0], "R5 pkt_data", pkt_data, exp_q[0]);
        chk(pkt_first === (m_oidx == 0), "R5 pkt_first", pkt_first, m_oidx == 0);
        chk(pkt_last === (m_oidx == 187), "R5 pkt_last", pkt_last, m_oidx == 187);
      end
      chk(locked === m_locked, "R2 locked", locked, m_locked);
      chk(drop_count === 16'(m_drop), "R7 drop_count", drop_count, m_drop);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ts_valid = 1'b0; ts_start = 1'b0; ts_data = 8'h47;
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit st);
    @(negedge clk);
    ts_valid = 1'b1; ts_start = st; ts_data = d;
  endtask

  task automatic send_pkt(input logic [12:0] pid, input bit terr, input bit pusi,
                          input logic [7:0] hb, input bit gaps, input int nb);
    logic [7:0] b;
    for (int i = 0; i < nb; i++) begin
      if (i == 0) b = hb;
      else if (i == 1) b = {terr, pusi, 1'b0, pid[12:8]};
      else if (i == 2) b = pid[7:0];
      else b = 8'((i * 5 + seed) & 8'h3F);
      if (gaps && (i % 3 == 0)) idle(2);
      send_byte(b, 1'b0);
    end
    seed = seed + 11;
  endtask

  task automatic tbl_write(input int idx, input bit en, input logic [12:0] pid);
    @(negedge clk);
    ts_valid = 1'b0; ts_start = 1'b0;
    cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_enable = en; cfg_pid = pid;
    t_en[idx] = en; t_pid[idx] = pid;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    int mode_save;
    mode_save = ready_mode;
    idle(1);
    for (int i = 0; i < 3000 && (exp_q.size() > 0 || pkt_valid); i++) idle(1);
    ready_mode = mode_save;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin t_en[i] = 0; t_pid[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 reset pkt_valid", pkt_valid, 0);
    chk(locked == 1'b0, "R1 reset locked", locked, 0);
    chk(drop_count == 16'd0, "R1 reset drop_count", drop_count, 0);

    // R1/R2: empty table, lock on third sync, pid 0 not forwarded
    send_pkt(13'h000, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h000, 0, 0, 8'h47, 0, 188);
    idle(1);
    chk(locked == 1'b0, "R2 not locked after two syncs", locked, 0);
    send_pkt(13'h000, 0, 0, 8'h47, 0, 188);
    idle(1);
    chk(locked == 1'b1, "R2 locked after third sync", locked, 1);
    drain();
    chk(fwd == 0, "R1 disabled table forwards nothing", fwd, 0);

    // R4 table contents
    tbl_write(0, 1, 13'h100);
    tbl_write(63, 1, 13'h1FFF);
    tbl_write(5, 0, 13'h0AA);
    ready_mode = 2;
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h0AA, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h1FFF, 0, 1, 8'h47, 0, 188);
    send_pkt(13'h101, 0, 0, 8'h47, 0, 188);
    drain();
    chk(fwd == 3, "R4 match and disabled entries", fwd, 3);
    ready_mode = 1;

    // R8 transport error discard
    drop_err_pkts = 1'b1;
    send_pkt(13'h100, 1, 0, 8'h47, 0, 188);
    drain();
    chk(fwd == 3, "R8 error packet discarded", fwd, 3);
    drop_err_pkts = 1'b0;
    send_pkt(13'h100, 1, 0, 8'h47, 0, 188);
    drain();
    chk(fwd == 4, "R8 error packet passes when allowed", fwd, 4);
    chk(drop_count == 16'd0, "R8 discard not counted", drop_count, 0);

    // R3 miss handling
    send_pkt(13'h100, 0, 0, 8'h00, 0, 188);
    idle(1);
    chk(locked == 1'b1, "R3 lock kept after one miss", locked, 1);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    drain();
    chk(fwd == 5, "R3 missed packet dropped, next forwarded", fwd, 5);
    send_pkt(13'h100, 0, 0, 8'h00, 0, 188);
    idle(1);
    chk(locked == 1'b1, "R3 lock kept after first miss", locked, 1);
    send_pkt(13'h100, 0, 0, 8'h00, 0, 188);
    idle(1);
    chk(locked == 1'b0, "R3 lock lost after second miss", locked, 0);

    // relock
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    drain();
    chk(fwd == 6, "R2 relock forwards third packet only", fwd, 6);

    // R7 room rule under back-pressure
    ready_mode = 0;
    idle(2);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h1FFF, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h101, 0, 0, 8'h47, 0, 188);
    idle(3);
    chk(drop_count == 16'd1, "R7 one matching packet dropped", drop_count, 1);
    chk(pkt_valid == 1'b1, "R6 output held under back-pressure", pkt_valid, 1);
    ready_mode = 1;
    drain();
    chk(fwd == 8, "R7 two whole packets delivered", fwd, 8);

    // R9 restart mid-packet
    send_pkt(13'h100, 0, 0, 8'h47, 0, 100);
    send_byte(8'h00, 1'b1);
    idle(1);
    chk(locked == 1'b0, "R9 restart clears lock", locked, 0);
    drain();
    chk(fwd == 8, "R9 partial packet discarded", fwd, 8);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    send_pkt(13'h100, 0, 0, 8'h47, 0, 188);
    drain();
    chk(fwd == 9, "R9 relock after restart", fwd, 9);

    // R10 gaps with garbage sync bytes on invalid cycles
    send_pkt(13'h100, 0, 0, 8'h47, 1, 188);
    send_pkt(13'h1FFF, 0, 0, 8'h47, 1, 188);
    drain();
    chk(fwd == 11, "R10 gapped packets forwarded", fwd, 11);
    chk(locked == 1'b1, "R10 lock unaffected by gaps", locked, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule